// File: doc/BRIEF.md
# Miss status holding register file

This block lets an in-order pipeline keep running after a load misses in the data cache. It keeps a few entries, and each entry covers one outstanding memory line. Inside an entry there is one slot per word of the line, and each slot names the destination register that waits for that word. A second load that misses on a line already held in an entry joins that entry in a free word slot and sends nothing more to memory. A load that misses on a new line takes a free entry and queues one line request.

The block also keeps a full/empty scoreboard with one bit per architectural register. When a miss is accepted, the bit for its destination is cleared. The load then leaves the pipeline at once. Decode asks whether either of two source registers is still empty and stalls only when one is.

When a line returns from memory, it is matched to its entry by line address. Lines may return in any order. The waiting words are then written to their registers one per cycle, and each write marks its register full again.

Top module: `mshr_file`

## Requirements
- R1: After reset no register is pending (stall query low for every index), no memory request or writeback is offered, and the error flag is low.
- R2: A miss to a line that no collecting entry holds is accepted in the same cycle it is offered. From the next cycle its destination reads as pending, and a request for its line is queued.
- R3: A miss to a line that an entry already holds (requested or not, data not yet back) is merged into that entry's word slot. It produces no second memory request.
- R4: `miss_ready` is low, and the miss is not taken, when any of these holds: the destination is already pending, the line is new and all entries are in use, or the line is held and its word slot is already claimed.
- R5: Line requests are offered in allocation order with a valid/ready handshake. An offered line stays unchanged until it is accepted.
- R6: A returned line writes each claimed word to its register in rising word index order, one per cycle, starting the cycle after the return. Word w of `fill_data` is bits [32w+31:32w].
- R7: Each writeback marks its register full from the next cycle. The entry is freed after its last write and can then be allocated again.
- R8: `dec_stall` is high exactly when `dec_rs_a` or `dec_rs_b` names a pending register.
- R9: A returned line that matches no waiting entry writes nothing and sets `fill_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Load unit offers a missing load |
| miss_ready | output | 1 | Miss is taken this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | log2(WORDS) | Word index within the line |
| miss_rd | input | log2(NREG) | Destination register |
| req_valid | output | 1 | Line request to memory is offered |
| req_ready | input | 1 | Memory accepts the request |
| req_line | output | LINE_W | Line address requested |
| fill_valid | input | 1 | A line returns from memory |
| fill_line | input | LINE_W | Line address of the returned data |
| fill_data | input | WORDS*DW | Returned line, word 0 in the low bits |
| wb_valid | output | 1 | Register write this cycle |
| wb_rd | output | log2(NREG) | Register written |
| wb_data | output | DW | Value written |
| dec_rs_a | input | log2(NREG) | First decode source register |
| dec_rs_b | input | log2(NREG) | Second decode source register |
| dec_stall | output | 1 | A queried source is pending |
| fill_err | output | 1 | Sticky: a return matched no entry |

## Verification
The bench sweeps every non-empty set of claimed word slots, merging them in falling word order. A design that wrote back in merge order, or that sent a request per merge, would produce writes in the wrong order or leave an extra request offered.

It fills all entries and returns lines out of order. This catches a design that matched returns by position instead of by address, or that never freed an entry.

It offers misses to a claimed slot, to a pending destination and to a full table. A design that lost a waiter, or wrote one register twice, would accept one of these.

A return for an unknown line must leave the writeback port idle and raise the flag for good.

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NENT   = 4,
  parameter int WORDS  = 4,
  parameter int DW     = 32,
  parameter int NREG   = 32,
  parameter int LINE_W = 28
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       miss_valid,
  output logic                       miss_ready,
  input  logic [LINE_W-1:0]          miss_line,
  input  logic [$clog2(WORDS)-1:0]   miss_word,
  input  logic [$clog2(NREG)-1:0]    miss_rd,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [LINE_W-1:0]          req_line,
  input  logic                       fill_valid,
  input  logic [LINE_W-1:0]          fill_line,
  input  logic [WORDS*DW-1:0]        fill_data,
  output logic                       wb_valid,
  output logic [$clog2(NREG)-1:0]    wb_rd,
  output logic [DW-1:0]              wb_data,
  input  logic [$clog2(NREG)-1:0]    dec_rs_a,
  input  logic [$clog2(NREG)-1:0]    dec_rs_b,
  output logic                       dec_stall,
  output logic                       fill_err
);
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int WW = $clog2(WORDS);
  localparam int RW = $clog2(NREG);

  logic [NENT-1:0]     e_v, e_iss, e_drn;
  logic [LINE_W-1:0]   e_line [NENT];
  logic [WORDS-1:0]    e_sv   [NENT];
  logic [RW-1:0]       e_rd   [NENT][WORDS];
  logic [WORDS*DW-1:0] e_dat  [NENT];
  logic [NREG-1:0]     full;

  logic [EW-1:0] q [NENT];
  logic [EW-1:0] q_hd, q_tl;
  logic [EW:0]   q_cnt;

  logic          hit, free_any, fhit, drn_any;
  logic [EW-1:0] hit_e, free_e, fe, wb_e;
  logic [WW-1:0] wb_w;

  always_comb begin
    hit = 1'b0; hit_e = '0; free_any = 1'b0; free_e = '0;
    fhit = 1'b0; fe = '0; drn_any = 1'b0; wb_e = '0;
    for (int i = NENT-1; i >= 0; i--) begin
      if (e_v[i] && !e_drn[i] && e_line[i] == miss_line) begin
        hit = 1'b1; hit_e = EW'(i);
      end
      if (!e_v[i]) begin
        free_any = 1'b1; free_e = EW'(i);
      end
      if (e_v[i] && e_iss[i] && !e_drn[i] && e_line[i] == fill_line) begin
        fhit = 1'b1; fe = EW'(i);
      end
      if (e_drn[i]) begin
        drn_any = 1'b1; wb_e = EW'(i);
      end
    end
    wb_w = '0;
    for (int w = WORDS-1; w >= 0; w--)
      if (e_sv[wb_e][w]) wb_w = WW'(w);
  end

  assign miss_ready = full[miss_rd] && (hit ? !e_sv[hit_e][miss_word] : free_any);

  wire acc     = miss_valid && miss_ready;
  wire new_e   = acc && !hit;
  wire pop     = req_valid && req_ready;
  wire wb_last = (e_sv[wb_e] & ~(WORDS'(1) << wb_w)) == '0;

  assign req_valid = q_cnt != '0;
  assign req_line  = e_line[q[q_hd]];
  assign wb_valid  = drn_any;
  assign wb_rd     = e_rd[wb_e][wb_w];
  assign wb_data   = e_dat[wb_e][wb_w*DW +: DW];
  assign dec_stall = !full[dec_rs_a] || !full[dec_rs_b];

  function automatic logic [EW-1:0] nxt(input logic [EW-1:0] p);
    return (p == EW'(NENT-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0; e_iss <= '0; e_drn <= '0;
      for (int i = 0; i < NENT; i++) e_sv[i] <= '0;
      full <= '1;
      q_hd <= '0; q_tl <= '0; q_cnt <= '0;
      fill_err <= 1'b0;
    end else begin
      if (new_e) begin
        e_v[free_e]   <= 1'b1;
        e_iss[free_e] <= 1'b0;
        e_drn[free_e] <= 1'b0;
        e_line[free_e] <= miss_line;
        e_sv[free_e]  <= WORDS'(1) << miss_word;
        e_rd[free_e][miss_word] <= miss_rd;
        q[q_tl] <= free_e;
        q_tl    <= nxt(q_tl);
      end else if (acc) begin
        e_sv[hit_e][miss_word] <= 1'b1;
        e_rd[hit_e][miss_word] <= miss_rd;
      end
      if (pop) begin
        e_iss[q[q_hd]] <= 1'b1;
        q_hd <= nxt(q_hd);
      end
      q_cnt <= q_cnt + (EW+1)'(new_e) - (EW+1)'(pop);
      if (fill_valid) begin
        if (fhit) begin
          e_drn[fe] <= 1'b1;
          e_dat[fe] <= fill_data;
        end else begin
          fill_err <= 1'b1;
        end
      end
      if (drn_any) begin
        e_sv[wb_e][wb_w] <= 1'b0;
        full[wb_rd] <= 1'b1;
        if (wb_last) begin
          e_v[wb_e]   <= 1'b0;
          e_drn[wb_e] <= 1'b0;
        end
      end
      if (acc) full[miss_rd] <= 1'b0;
    end
  end
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int NREG   = 32,
  parameter int LINE_W = 28
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    miss_valid,
  input logic                    miss_ready,
  input logic [$clog2(NREG)-1:0] miss_rd,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [LINE_W-1:0]       req_line,
  input logic                    wb_valid,
  input logic [$clog2(NREG)-1:0] wb_rd,
  input logic                    fill_err,
  input logic [NREG-1:0]         full
);
  assert_miss_marks_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !full[$past(miss_rd)]);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_line));

  assert_wb_no_repeat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && $past(wb_valid) |-> wb_rd != $past(wb_rd));

  assert_wb_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> full[$past(wb_rd)]);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |=> fill_err);
endmodule

bind mshr_file mshr_file_chk #(.NREG(NREG), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .miss_rd(miss_rd), .req_valid(req_valid), .req_ready(req_ready),
  .req_line(req_line), .wb_valid(wb_valid), .wb_rd(wb_rd),
  .fill_err(fill_err), .full(full)
);

// File: tb/sim_mshr_file.sv
module sim_mshr_file;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         miss_valid, miss_ready;
  logic [27:0]  miss_line;
  logic [1:0]   miss_word;
  logic [4:0]   miss_rd;
  logic         req_valid, req_ready;
  logic [27:0]  req_line;
  logic         fill_valid;
  logic [27:0]  fill_line;
  logic [127:0] fill_data;
  logic         wb_valid;
  logic [4:0]   wb_rd;
  logic [31:0]  wb_data;
  logic [4:0]   dec_rs_a, dec_rs_b;
  logic         dec_stall, fill_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  mshr_file u0 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
    .miss_word(miss_word), .miss_rd(miss_rd),
    .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_data(wb_data),
    .dec_rs_a(dec_rs_a), .dec_rs_b(dec_rs_b), .dec_stall(dec_stall),
    .fill_err(fill_err)
  );

  function automatic logic [31:0] word_of(input logic [27:0] ln, input int w);
    return 32'(ln) * 32'd16 + 32'(w) * 32'd3 + 32'h1000_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic miss(input logic [27:0] ln, input int w, input int rd, input bit exp_rdy, input string req);
    miss_valid = 1'b1; miss_line = ln; miss_word = 2'(w); miss_rd = 5'(rd);
    #1 chk(miss_ready == exp_rdy, req, 32'(miss_ready), 32'(exp_rdy));
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic stall_is(input int ra, input int rb, input bit exp, input string req);
    dec_rs_a = 5'(ra); dec_rs_b = 5'(rb);
    #1 chk(dec_stall == exp, req, 32'(dec_stall), 32'(exp));
    @(negedge clk);
  endtask

  task automatic take_req(input logic [27:0] ln, input string req);
    chk(req_valid == 1'b1, req, 32'(req_valid), 32'd1);
    chk(req_line == ln, req, 32'(req_line), 32'(ln));
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  task automatic fill(input logic [27:0] ln);
    fill_valid = 1'b1; fill_line = ln;
    for (int w = 0; w < 4; w++) fill_data[w*32 +: 32] = word_of(ln, w);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_wb(input int rd, input logic [27:0] ln, input int w, input string req);
    chk(wb_valid == 1'b1, req, 32'(wb_valid), 32'd1);
    chk(wb_rd == 5'(rd), req, 32'(wb_rd), 32'(rd));
    chk(wb_data == word_of(ln, w), req, wb_data, word_of(ln, w));
    @(negedge clk);
  endtask

  task automatic idle_wb(input string req);
    chk(wb_valid == 1'b0, req, 32'(wb_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; miss_valid = 1'b0; miss_line = '0; miss_word = '0; miss_rd = '0;
    req_ready = 1'b0; fill_valid = 1'b0; fill_line = '0; fill_data = '0;
    dec_rs_a = '0; dec_rs_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int r = 0; r < 32; r++) stall_is(r, r, 1'b0, "R1");
    chk(req_valid == 1'b0, "R1", 32'(req_valid), 32'd0);
    idle_wb("R1");
    chk(fill_err == 1'b0, "R1", 32'(fill_err), 32'd0);

    // R2, R3, R4, R8: allocate, merge, refusals
    miss(28'h100, 1, 5, 1'b1, "R2");
    stall_is(5, 0, 1'b1, "R2");
    stall_is(6, 0, 1'b0, "R8");
    stall_is(0, 5, 1'b1, "R8");
    chk(req_valid == 1'b1 && req_line == 28'h100, "R2", 32'(req_line), 32'h100);
    miss(28'h100, 3, 7, 1'b1, "R3");
    miss(28'h100, 1, 9, 1'b0, "R4");
    miss(28'h200, 0, 5, 1'b0, "R4");
    take_req(28'h100, "R3");
    chk(req_valid == 1'b0, "R3", 32'(req_valid), 32'd0);
    fill(28'h100);
    expect_wb(5, 28'h100, 1, "R6");
    expect_wb(7, 28'h100, 3, "R6");
    idle_wb("R6");
    stall_is(5, 7, 1'b0, "R7");

    // R4, R5, R6, R7: full table, order, out-of-order returns
    for (int i = 0; i < 4; i++) miss(28'h300 + 28'(i), i, 10 + i, 1'b1, "R2");
    miss(28'h400, 0, 20, 1'b0, "R4");
    for (int i = 0; i < 4; i++) take_req(28'h300 + 28'(i), "R5");
    chk(req_valid == 1'b0, "R5", 32'(req_valid), 32'd0);
    fill(28'h302);
    expect_wb(12, 28'h302, 2, "R6");
    fill(28'h300);
    expect_wb(10, 28'h300, 0, "R6");
    miss(28'h400, 0, 20, 1'b1, "R7");
    take_req(28'h400, "R5");
    fill(28'h303);
    expect_wb(13, 28'h303, 3, "R6");
    fill(28'h301);
    expect_wb(11, 28'h301, 1, "R6");
    fill(28'h400);
    expect_wb(20, 28'h400, 0, "R6");
    idle_wb("R7");
    stall_is(10, 20, 1'b0, "R7");

    // R9: unmatched return
    fill(28'h777);
    idle_wb("R9");
    chk(fill_err == 1'b1, "R9", 32'(fill_err), 32'd1);
    repeat (3) @(negedge clk);
    chk(fill_err == 1'b1, "R9", 32'(fill_err), 32'd1);

    // R3, R6, R8: every slot subset, merged in falling word order
    for (int m = 1; m < 16; m++) begin
      for (int w = 3; w >= 0; w--)
        if (m[w]) miss(28'h500 + 28'(m), w, 16 + w, 1'b1, "R3");
      for (int w = 0; w < 4; w++) stall_is(16 + w, 0, m[w], "R8");
      take_req(28'h500 + 28'(m), "R3");
      chk(req_valid == 1'b0, "R3", 32'(req_valid), 32'd0);
      fill(28'h500 + 28'(m));
      for (int w = 0; w < 4; w++)
        if (m[w]) expect_wb(16 + w, 28'h500 + 28'(m), w, "R6");
      idle_wb("R6");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule